// File: doc/BRIEF.md
# Memory Access Port with Banked Data Window

This block sits behind a debug port and turns register-level requests into single-beat transfers on a generic valid/ready memory bus. The debug side sets up an access through a control word, which holds the transfer size and the increment mode, and a transfer address register. It then starts bus transfers in one of two ways. It can access the data register, which uses the transfer address directly. It can instead access one of four banked data registers, which reach the four words of the 16-byte-aligned window that the transfer address points into.

Each data access launches exactly one bus transfer and holds the port busy until the memory answers. The debug side must wait for the response before it issues the next request. A request that arrives while the port is busy is dropped and raises a sticky overrun flag. A bus error raises a sticky error flag. Both flags stay set until the debug side pulses the clear input. With increment enabled, the transfer address advances by the access size after each data-register transfer. The increment never carries out of the low ten bits, so the address wraps inside its 1 KB block.

Top module: `memap_window`

## Requirements
- R1: After reset, busy, mem_valid, rsp_valid and both sticky flags are low. The control word reads 0x00000002 (word size, increment off) and the transfer address reads 0.
- R2: Offset 0x00 is the control word. Bits 1:0 hold the size (0 byte, 1 halfword, 2 word; a written 3 is stored as 2) and bit 4 enables increment. It reads back those fields with all other bits zero. Every accepted register access (not a data access) answers with rsp_valid one cycle later, and a write answers with data 0.
- R3: Offset 0x04 is the transfer address. It reads back the last value written.
- R4: An access to offset 0x0C starts one bus transfer at the transfer address. mem_valid and busy rise in the cycle after acceptance. Address, byte enables and write data hold until mem_ready is sampled. rsp_valid pulses in the cycle after that edge and carries the read data (0 for writes).
- R5: The byte enables depend on the size and on address bits 1:0. A byte access sets bit addr[1:0]. A halfword access sets 4'b0011 when addr[1] is 0 and 4'b1100 when it is 1. A word access sets 4'b1111. Write data passes through on all lanes unchanged. Read data is returned with the lanes that are not enabled forced to zero.
- R6: With increment on, each offset-0x0C transfer advances the transfer address by 1, 2 or 4 bytes for the byte, halfword or word size. With increment off, the address is unchanged.
- R7: The increment changes only address bits 9:0. Bits 31:10 never change except through a write to offset 0x04.
- R8: An access to offsets 0x10, 0x14, 0x18 or 0x1C targets {TAR[31:4], offset[3:2], 2'b00} at the current size. It never changes the transfer address, even with increment on.
- R9: A request that arrives while busy is high is dropped and sets the overrun flag. This includes a request in the same cycle that mem_ready completes the transfer. A dropped request starts no transfer, changes no register and gives no response.
- R10: A bus error response (mem_err with mem_ready) sets the error flag and ends the transfer without a retry. A read returns 0, and the response still arrives.
- R11: A pulse on flag_clear clears both sticky flags. A flag set in the same cycle stays set.
- R12: Offset 0xF8 reads the BASE_ADDR parameter and ignores writes. All other unused offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request strobe from the debug port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 8 | Register offset |
| req_wdata | input | 32 | Write data, byte lanes already placed |
| flag_clear | input | 1 | Clears both sticky flags |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Response data |
| busy | output | 1 | Bus transfer in flight |
| ovr_sticky | output | 1 | Sticky overrun flag |
| err_sticky | output | 1 | Sticky bus error flag |
| mem_valid | output | 1 | Bus request valid |
| mem_write | output | 1 | Bus write |
| mem_addr | output | 32 | Bus byte address |
| mem_be | output | 4 | Bus byte enables |
| mem_wdata | output | 32 | Bus write data |
| mem_ready | input | 1 | Bus completion |
| mem_rdata | input | 32 | Bus read data |
| mem_err | input | 1 | Bus error with completion |

## Verification
Two events can meet in the same cycle: the completion of a bus transfer and the arrival of a new debug request. The bench counts memory latency cycles so that the second request lands on exactly the edge where mem_ready is sampled. It then requires an overrun flag, a single bus handshake, and a transfer address that advanced only once. A second collision drives flag_clear in the same cycle as an overrun request and requires the flag to stay set.

// File: rtl/memap_pkg.sv
// Shared types and helpers for the memory access port.
// Assumes a 32-bit data path split into four byte lanes.
package memap_pkg;
    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 8 * WORD_BYTES;
    localparam int OFF_W      = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xsize_e;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_ADDR,
        SEL_DATA,
        SEL_BANK,
        SEL_BASE,
        SEL_NONE
    } regsel_e;

    // Map a register offset onto the register it names.
    function automatic regsel_e decode_off(input logic [OFF_W-1:0] off);
        regsel_e r;
        if (off[7:4] == 4'h1) begin
            r = SEL_BANK;
        end else begin
            case (off[7:2])
                6'h00:   r = SEL_CTRL;
                6'h01:   r = SEL_ADDR;
                6'h03:   r = SEL_DATA;
                6'h3E:   r = SEL_BASE;
                default: r = SEL_NONE;
            endcase
        end
        return r;
    endfunction

    // Byte enables for a given size and low address bits.
    function automatic logic [WORD_BYTES-1:0] lane_mask(input xsize_e sz, input logic [1:0] a);
        logic [3:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001 << a;
            SZ_HALF: m = a[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    // Address step in bytes for a given size.
    function automatic logic [2:0] size_step(input xsize_e sz);
        logic [2:0] s;
        case (sz)
            SZ_BYTE: s = 3'd1;
            SZ_HALF: s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/memap_regs.sv
// Control word and transfer address registers.
// Holds size and increment mode and advances the transfer address inside a
// 2**WRAP_BITS byte block after each data-register transfer.
// Assumes ADDR_W <= DATA_W and WRAP_BITS < ADDR_W.
module memap_regs
    import memap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WRAP_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              addr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step_go,
    input  logic              bank_go,
    output xsize_e            size_o,
    output logic              inc_o,
    output logic [ADDR_W-1:0] tar_o
);
    localparam int HI_W = ADDR_W - WRAP_BITS;

    xsize_e              size_q;
    logic                inc_q;
    logic [ADDR_W-1:0]   tar_q;
    logic [WRAP_BITS-1:0] low_next;
    logic [HI_W-1:0]     high_keep;

    // Next low address bits; carry out of the block is discarded.
    always_comb begin
        low_next  = tar_q[WRAP_BITS-1:0] + WRAP_BITS'(size_step(size_q));
        high_keep = tar_q[ADDR_W-1:WRAP_BITS];
    end

    // Control word fields, with the reserved size mapped to word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_WORD;
            inc_q  <= 1'b0;
        end else if (ctrl_wr) begin
            size_q <= (wdata[1:0] == 2'd3) ? SZ_WORD : xsize_e'(wdata[1:0]);
            inc_q  <= wdata[4];
        end
    end

    // Transfer address: software write or post-transfer increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tar_q <= '0;
        end else if (addr_wr) begin
            tar_q <= wdata[ADDR_W-1:0];
        end else if (step_go && inc_q) begin
            tar_q <= {high_keep, low_next};
        end
    end

    assign size_o = size_q;
    assign inc_o  = inc_q;
    assign tar_o  = tar_q;

    // R7
    tar_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_wr |=> tar_q[ADDR_W-1:WRAP_BITS] == $past(tar_q[ADDR_W-1:WRAP_BITS]));

    // R8
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_go && !addr_wr) |=> $stable(tar_q));

    // R6
    inc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_q && !addr_wr) |=> $stable(tar_q));
endmodule

// File: rtl/memap_lanes.sv
// Byte lane logic: makes byte enables from size and address, and zeroes
// the read data lanes that were not enabled. Purely combinational.
module memap_lanes
    import memap_pkg::*;
(
    input  xsize_e                size_i,
    input  logic [1:0]            addr_lo_i,
    output logic [WORD_BYTES-1:0] be_o,
    input  logic [WORD_BYTES-1:0] keep_i,
    input  logic [DATA_W-1:0]     raw_i,
    output logic [DATA_W-1:0]     kept_o
);
    // Enable pattern for the transfer about to start.
    assign be_o = lane_mask(size_i, addr_lo_i);

    // One mux per byte lane on the returned data.
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        assign kept_o[8*b +: 8] = keep_i[b] ? raw_i[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/memap_xfer.sv
// Single-beat bus engine with sticky overrun and error flags.
// Holds one transfer on the valid/ready bus until it completes, captures the
// response and flags. Assumes launch_i is only asserted while idle.
module memap_xfer
    import memap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch_i,
    input  logic                  launch_wr_i,
    input  logic [ADDR_W-1:0]     launch_addr_i,
    input  logic [WORD_BYTES-1:0] launch_be_i,
    input  logic [DATA_W-1:0]     launch_wdata_i,
    input  logic                  overrun_i,
    input  logic                  flag_clear_i,
    output logic                  mem_valid_o,
    output logic                  mem_write_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [WORD_BYTES-1:0] mem_be_o,
    output logic [DATA_W-1:0]     mem_wdata_o,
    input  logic                  mem_ready_i,
    input  logic                  mem_err_i,
    input  logic [DATA_W-1:0]     kept_rdata_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [DATA_W-1:0]     done_rdata_o,
    output logic                  ovr_o,
    output logic                  err_o
);
    logic                  valid_q, write_q, done_q, ovr_q, err_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [WORD_BYTES-1:0] be_q;
    logic [DATA_W-1:0]     wdata_q, rdata_q;
    logic                  complete;

    assign complete = valid_q && mem_ready_i;

    // Request register: load on launch, drop on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (launch_i) begin
            valid_q <= 1'b1;
            write_q <= launch_wr_i;
            addr_q  <= launch_addr_i;
            be_q    <= launch_be_i;
            wdata_q <= launch_wdata_i;
        end else if (complete) begin
            valid_q <= 1'b0;
        end
    end

    // Response capture: error and write completions return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= complete;
            if (complete) begin
                rdata_q <= (mem_err_i || write_q) ? '0 : kept_rdata_i;
            end
        end
    end

    // Sticky flags: a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ovr_q <= (ovr_q && !flag_clear_i) || overrun_i;
            err_q <= (err_q && !flag_clear_i) || (complete && mem_err_i);
        end
    end

    assign mem_valid_o  = valid_q;
    assign mem_write_o  = write_q;
    assign mem_addr_o   = addr_q;
    assign mem_be_o     = be_q;
    assign mem_wdata_o  = wdata_q;
    assign busy_o       = valid_q;
    assign done_o       = done_q;
    assign done_rdata_o = rdata_q;
    assign ovr_o        = ovr_q;
    assign err_o        = err_q;

    // R4
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !mem_ready_i) |=> (valid_q && $stable(addr_q) && $stable(be_q) && $stable(wdata_q)));

    // R4
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (!valid_q && done_q));

    // R9
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !valid_q);

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_i |=> ovr_q);

    // R10
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && mem_err_i) |=> (err_q && !valid_q));

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear_i && !overrun_i && !(complete && mem_err_i)) |=> (!ovr_q && !err_q));

    // R5
    be_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (be_q != '0));
endmodule

// File: rtl/memap_window.sv
// Memory access port top: decodes debug register requests, launches
// single-beat bus transfers for the data and banked registers, and returns
// register or bus responses. Assumes the debug side waits for a response
// before issuing the next request; earlier requests count as overruns.
module memap_window
    import memap_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WRAP_BITS = 10,
    parameter logic [31:0] BASE_ADDR = 32'hE00F_F003
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_off,
    input  logic [31:0] req_wdata,
    input  logic        flag_clear,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        busy,
    output logic        ovr_sticky,
    output logic        err_sticky,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err
);
    regsel_e               sel;
    logic                  accept, overrun, data_go, bank_go, step_go;
    logic                  ctrl_wr, addr_wr;
    xsize_e                size;
    logic                  inc_on;
    logic [ADDR_W-1:0]     tar;
    logic [ADDR_W-1:0]     xfer_addr;
    logic [WORD_BYTES-1:0] launch_be, held_be;
    logic [DATA_W-1:0]     kept_rdata, done_rdata;
    logic                  done;
    logic                  reg_rsp_q;
    logic [DATA_W-1:0]     reg_rdata_q, reg_rdata;

    // Request classification.
    always_comb begin
        sel     = decode_off(req_off);
        accept  = req_valid && !busy;
        overrun = req_valid && busy;
        bank_go = accept && (sel == SEL_BANK);
        step_go = accept && (sel == SEL_DATA);
        data_go = bank_go || step_go;
        ctrl_wr = accept && req_write && (sel == SEL_CTRL);
        addr_wr = accept && req_write && (sel == SEL_ADDR);
    end

    // Bus address: the transfer address, or the window word for a bank.
    always_comb begin
        if (sel == SEL_BANK) begin
            xfer_addr = {tar[ADDR_W-1:4], req_off[3:2], 2'b00};
        end else begin
            xfer_addr = tar;
        end
    end

    // Read value for the register side.
    always_comb begin
        case (sel)
            SEL_CTRL: reg_rdata = {27'd0, inc_on, 2'b00, size};
            SEL_ADDR: reg_rdata = DATA_W'(tar);
            SEL_BASE: reg_rdata = BASE_ADDR;
            default:  reg_rdata = '0;
        endcase
    end

    memap_regs #(
        .ADDR_W    (ADDR_W),
        .WRAP_BITS (WRAP_BITS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .addr_wr (addr_wr),
        .wdata   (req_wdata),
        .step_go (step_go),
        .bank_go (bank_go),
        .size_o  (size),
        .inc_o   (inc_on),
        .tar_o   (tar)
    );

    memap_lanes u_lanes (
        .size_i    (size),
        .addr_lo_i (xfer_addr[1:0]),
        .be_o      (launch_be),
        .keep_i    (held_be),
        .raw_i     (mem_rdata),
        .kept_o    (kept_rdata)
    );

    memap_xfer #(
        .ADDR_W (ADDR_W)
    ) u_xfer (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch_i       (data_go),
        .launch_wr_i    (req_write),
        .launch_addr_i  (xfer_addr),
        .launch_be_i    (launch_be),
        .launch_wdata_i (req_wdata),
        .overrun_i      (overrun),
        .flag_clear_i   (flag_clear),
        .mem_valid_o    (mem_valid),
        .mem_write_o    (mem_write),
        .mem_addr_o     (mem_addr),
        .mem_be_o       (held_be),
        .mem_wdata_o    (mem_wdata),
        .mem_ready_i    (mem_ready),
        .mem_err_i      (mem_err),
        .kept_rdata_i   (kept_rdata),
        .busy_o         (busy),
        .done_o         (done),
        .done_rdata_o   (done_rdata),
        .ovr_o          (ovr_sticky),
        .err_o          (err_sticky)
    );

    // Register-side response, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rsp_q   <= 1'b0;
            reg_rdata_q <= '0;
        end else begin
            reg_rsp_q   <= accept && !data_go;
            reg_rdata_q <= req_write ? '0 : reg_rdata;
        end
    end

    assign mem_be    = held_be;
    assign rsp_valid = reg_rsp_q || done;
    assign rsp_rdata = reg_rsp_q ? reg_rdata_q : done_rdata;

    // R9
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rsp_q && done));

    // R9
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !mem_ready) |=> !reg_rsp_q && !done);
endmodule

// File: tb/memap_window_test.sv
module memap_window_test;
    localparam logic [31:0] BASE = 32'hE00F_F003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_off = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic        flag_clear = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        busy, ovr_sticky, err_sticky;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_err = 1'b0;

    memap_window #(.BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_off(req_off), .req_wdata(req_wdata), .flag_clear(flag_clear),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
        .ovr_sticky(ovr_sticky), .err_sticky(err_sticky),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct { logic [31:0] v; int rq; } exp_t;
    exp_t sbq[$];

    // Memory model state.
    logic [31:0] mem_m [0:255];
    int          lat = 0;
    int          wait_cnt = 0;
    int          hs = 0;
    logic [31:0] last_addr = 32'h0;
    logic [31:0] last_wd = 32'h0;
    logic [3:0]  last_be = 4'h0;

    function automatic logic [31:0] pat(int i);
        return {8'(i), 8'(i ^ 'h5A), 8'(~i), 8'(i + 'h11)};
    endfunction

    task automatic chk(bit ok, int rq, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Monitor: pop and compare each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R9 unexpected response: actual=%h expected=none", rsp_rdata);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(rsp_rdata == e.v, e.rq, "response data", rsp_rdata, e.v);
            end
        end
    end

    // Memory model: latency counter, error region at 0xE-------.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            mem_err   = 1'b0;
        end else if (mem_valid) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                wait_cnt  = 0;
                mem_ready = 1'b1;
                mem_err   = (mem_addr[31:28] == 4'hE);
                hs++;
                last_addr = mem_addr;
                last_be   = mem_be;
                last_wd   = mem_wdata;
                mem_rdata = mem_err ? 32'hDEAD_BEEF : mem_m[mem_addr[9:2]];
                if (mem_write && !mem_err) begin
                    for (int b = 0; b < 4; b++) begin
                        if (mem_be[b]) mem_m[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                    end
                end
            end
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver: queue the expected response, send one request, wait for it.
    task automatic access(bit wr, logic [7:0] off, logic [31:0] wd, logic [31:0] exp, int rq);
        sbq.push_back('{v: exp, rq: rq});
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_off = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
    endtask

    int hs0;
    logic [31:0] w;

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(!busy && !mem_valid && !rsp_valid, 1, "idle after reset", {29'd0, busy, mem_valid, rsp_valid}, 32'h0);
        chk(!ovr_sticky && !err_sticky, 1, "flags after reset", {30'd0, ovr_sticky, err_sticky}, 32'h0);
        access(1'b0, 8'h00, 0, 32'h0000_0002, 1);   // R1
        access(1'b0, 8'h04, 0, 32'h0, 1);           // R1

        // R2 control word fields and reserved size
        access(1'b1, 8'h00, 32'hFFFF_FF13, 32'h0, 2);
        access(1'b0, 8'h00, 0, 32'h0000_0012, 2);
        access(1'b1, 8'h00, 32'h0000_0001, 32'h0, 2);
        access(1'b0, 8'h00, 0, 32'h0000_0001, 2);

        // R3 transfer address
        access(1'b1, 8'h04, 32'h0000_0040, 32'h0, 3);
        access(1'b0, 8'h04, 0, 32'h0000_0040, 3);

        // R4 word read through the data register
        access(1'b1, 8'h00, 32'h2, 32'h0, 4);
        lat = 2;
        hs0 = hs;
        access(1'b0, 8'h0C, 0, pat('h10), 4);
        chk(last_addr == 32'h40, 4, "bus address", last_addr, 32'h40);
        chk(hs == hs0 + 1, 4, "one handshake", hs, hs0 + 1);

        // R4 busy timing on a write
        sbq.push_back('{v: 32'h0, rq: 4});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_off = 8'h0C; req_wdata = 32'hCAFE_F00D;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && mem_valid && mem_write, 4, "busy in cycle after acceptance", {29'd0, busy, mem_valid, mem_write}, 32'h7);
        while (sbq.size() != 0) @(negedge clk);
        chk(!busy, 4, "idle after response", {31'd0, busy}, 32'h0);
        access(1'b0, 8'h0C, 0, 32'hCAFE_F00D, 4);
        access(1'b0, 8'h04, 0, 32'h40, 6);          // R6 increment off keeps address

        // R5 byte write with increment, lane 1
        lat = 0;
        access(1'b1, 8'h00, 32'h10, 32'h0, 5);
        access(1'b1, 8'h04, 32'h81, 32'h0, 5);
        access(1'b1, 8'h0C, 32'h0000_AB00, 32'h0, 5);
        chk(last_be == 4'b0010, 5, "byte enable lane 1", {28'd0, last_be}, 32'h2);
        chk(last_wd == 32'h0000_AB00, 5, "write data unchanged", last_wd, 32'h0000_AB00);
        access(1'b0, 8'h04, 0, 32'h82, 6);          // R6 byte step
        // R5 halfword read, upper lanes
        access(1'b1, 8'h00, 32'h11, 32'h0, 5);
        w = ((pat('h20) & ~32'h0000_FF00) | 32'h0000_AB00) & 32'hFFFF_0000;
        access(1'b0, 8'h0C, 0, w, 5);
        chk(last_be == 4'b1100, 5, "halfword enable", {28'd0, last_be}, 32'hC);
        access(1'b0, 8'h04, 0, 32'h84, 6);          // R6 halfword step

        // R7 wrap inside the 1 KB block
        access(1'b1, 8'h00, 32'h12, 32'h0, 7);
        access(1'b1, 8'h04, 32'h5A5A_03FC, 32'h0, 7);
        access(1'b0, 8'h0C, 0, pat('hFF), 7);
        chk(last_addr == 32'h5A5A_03FC, 7, "address before wrap", last_addr, 32'h5A5A_03FC);
        access(1'b0, 8'h04, 0, 32'h5A5A_0000, 7);

        // R8 banked window
        access(1'b1, 8'h00, 32'h02, 32'h0, 8);
        access(1'b1, 8'h04, 32'h0000_0123, 32'h0, 8);
        access(1'b0, 8'h18, 0, pat('h4A), 8);
        chk(last_addr == 32'h128, 8, "bank 2 address", last_addr, 32'h128);
        access(1'b1, 8'h00, 32'h12, 32'h0, 8);
        access(1'b0, 8'h10, 0, pat('h48), 8);
        chk(last_addr == 32'h120, 8, "bank 0 address", last_addr, 32'h120);
        access(1'b0, 8'h04, 0, 32'h123, 8);

        // R9 request while busy is dropped
        access(1'b1, 8'h04, 32'h200, 32'h0, 9);
        lat = 3;
        hs0 = hs;
        sbq.push_back('{v: pat('h80), rq: 9});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_off = 8'h0C;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(ovr_sticky, 9, "overrun flag", {31'd0, ovr_sticky}, 32'h1);
        chk(hs == hs0 + 1, 9, "dropped request not launched", hs, hs0 + 1);
        access(1'b0, 8'h04, 0, 32'h204, 9);
        pulse_clear();
        chk(!ovr_sticky, 11, "clear overrun", {31'd0, ovr_sticky}, 32'h0);   // R11

        // R9 request on the completion edge
        access(1'b1, 8'h04, 32'h300, 32'h0, 9);
        lat = 2;
        hs0 = hs;
        sbq.push_back('{v: pat('hC0), rq: 9});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_off = 8'h0C;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(ovr_sticky, 9, "overrun on completion edge", {31'd0, ovr_sticky}, 32'h1);
        chk(hs == hs0 + 1, 9, "single handshake on collision", hs, hs0 + 1);
        access(1'b0, 8'h04, 0, 32'h304, 9);
        pulse_clear();

        // R11 set wins over clear in the same cycle
        lat = 3;
        sbq.push_back('{v: pat('hC1), rq: 11});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_off = 8'h0C;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; flag_clear = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; flag_clear = 1'b0;
        chk(ovr_sticky, 11, "set wins over clear", {31'd0, ovr_sticky}, 32'h1);
        while (sbq.size() != 0) @(negedge clk);
        pulse_clear();
        chk(!ovr_sticky, 11, "clear after collision", {31'd0, ovr_sticky}, 32'h0);

        // R10 bus error
        lat = 1;
        access(1'b1, 8'h00, 32'h02, 32'h0, 10);
        access(1'b1, 8'h04, 32'hE000_0010, 32'h0, 10);
        hs0 = hs;
        access(1'b0, 8'h0C, 0, 32'h0, 10);
        repeat (5) @(negedge clk);
        chk(err_sticky, 10, "error flag", {31'd0, err_sticky}, 32'h1);
        chk(hs == hs0 + 1, 10, "no retry", hs, hs0 + 1);
        access(1'b1, 8'h0C, 32'h1111_1111, 32'h0, 10);
        access(1'b1, 8'h04, 32'h0000_0010, 32'h0, 10);
        access(1'b0, 8'h0C, 0, pat(4), 10);
        pulse_clear();
        chk(!err_sticky, 11, "clear error", {31'd0, err_sticky}, 32'h0);

        // R12 base register and unused offsets
        access(1'b0, 8'hF8, 0, BASE, 12);
        access(1'b1, 8'hF8, 32'h0, 32'h0, 12);
        access(1'b0, 8'hF8, 0, BASE, 12);
        access(1'b0, 8'h08, 0, 32'h0, 12);
        access(1'b0, 8'h20, 0, 32'h0, 12);
        access(1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0, 12);
        access(1'b0, 8'h00, 0, 32'h2, 12);
        access(1'b0, 8'h04, 0, 32'h10, 12);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule